// File: doc/BRIEF.md
# Composite Video Sync Generator

This block produces the timing skeleton of a composite video picture from a single fixed-frequency clock. A pixel-clock counter sets the length of every line and the position of the line sync pulse. Each time it wraps, a line counter advances, which sets the frame length and places the frame sync pulse. Both 625-line-style (PAL, 50 Hz) and 525-line-style (NTSC, 60 Hz) progressive timing are available. A one-bit input picks the standard, and a new choice is applied only when a new frame begins.

A two-bit input picks how composite sync is built. In the simple mode the two active-low syncs are combined with an AND, so CSync stays low through the whole frame sync. In the inverting mode CSync follows line sync and is inverted while frame sync is active. In the serrated mode the lines around frame sync carry narrow equalising pulses at twice line rate, and the frame sync lines carry broad half-line pulses, each followed by a short high gap. The block also reports the current column and line and an active-picture flag. All outputs are registered together, so they always describe the same clock position.

Top module: `csync_gen`

## Requirements
- R1: The column output counts up by one each clock from 0 to H-1 and then returns to 0, where H is 1536 clocks for PAL (std_sel_i=0) and 1524 clocks for NTSC (std_sel_i=1) by default.
- R2: The line output advances by exactly one on the clock where the column wraps. It returns to 0 after line V-1, where V is 312 lines for PAL and 262 lines for NTSC.
- R3: hsync_no is low for columns 0 to HSYNC_CLKS-1 (113 by default) on every line and high elsewhere, so its falling edge always lands on column 0.
- R4: vsync_no is low for the whole of lines EQ_LINES to EQ_LINES+VS_LINES-1 (lines 3 to 5) and high on every other line, which gives one pulse per frame.
- R5: With cs_mode_i=0, csync_no is low whenever hsync_no or vsync_no is low. The unused code cs_mode_i=3 behaves the same way. A mode change shows on csync_no one clock later.
- R6: With cs_mode_i=1, csync_no equals the XNOR of hsync_no and vsync_no, so it is the inverse of hsync_no during frame sync lines.
- R7: With cs_mode_i=2, on lines 0-2 and 6-8 csync_no is low for columns [0, EQ_CLKS) and [H/2, H/2+EQ_CLKS) only, with EQ_CLKS = 56 by default.
- R8: With cs_mode_i=2, on lines 3-5 csync_no is low for columns [0, H/2-HSYNC_CLKS) and [H/2, H-HSYNC_CLKS) and high elsewhere. On all remaining lines it equals hsync_no.
- R9: active_o is high exactly when the column is in [H_ACT_START, H_ACT_START+H_ACT_CLKS) and the line is in [V_ACT_START, V_ACT_START+V_ACT_LINES).
- R10: std_sel_i is sampled only on the last clock of a frame. The first frame after reset always uses PAL timing, whatever std_sel_i is.
- R11: While rst_ni is low, column and line read 0, all three syncs read high and active_o reads low. Reset is applied at once and removed on the second clock edge after rst_ni rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| std_sel_i | input | 1 | Standard select: 0 PAL, 1 NTSC |
| cs_mode_i | input | 2 | Composite sync build: 0 AND, 1 XNOR, 2 serrated, 3 as 0 |
| hsync_no | output | 1 | Line sync, active low |
| vsync_no | output | 1 | Frame sync, active low |
| csync_no | output | 1 | Composite sync, active low |
| active_o | output | 1 | High inside the active picture area |
| x_o | output | HW | Current column |
| y_o | output | VW | Current line |

## Verification
Several properties are checked on every clock. The column never exceeds the line end. The line count holds between column wraps and steps by one when the column wraps. The standard latch changes only at a frame boundary. In AND mode csync is low whenever vsync is low, and vsync only falls inside its line window. The exact pulse shapes can only be shown by the bench scenarios: serrated equalising and broad pulses at the half-line point, the XNOR inversion, and the active window. The same holds for frame lengths after a standard switch, and for the PAL first frame after reset while NTSC is already requested. The bench compares every output against a model built from the column, line and standard it tracks itself.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic [1:0] {
    CS_AND  = 2'd0,
    CS_XNOR = 2'd1,
    CS_SERR = 2'd2,
    CS_RSVD = 2'd3
  } cs_mode_e;

  typedef enum logic {
    STD_PAL  = 1'b0,
    STD_NTSC = 1'b1
  } vid_std_e;
endpackage

// File: rtl/csg_rst_sync.sv
module csg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;
endmodule

// File: rtl/csg_hcount.sv
module csg_hcount #(
  parameter int HW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [HW-1:0] last_i,
  output logic [HW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_d;

  always_comb begin
    wrap_o = en_i && (cnt_q == last_i);
    cnt_d  = cnt_q;
    if (en_i) begin
      if (cnt_q == last_i) cnt_d = '0;
      else                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1: column stays inside the current line length
  assert_hcnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/csg_vcount.sv
module csg_vcount #(
  parameter int VW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [VW-1:0] last_i,
  output logic [VW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [VW-1:0] cnt_q;
  logic [VW-1:0] cnt_d;

  always_comb begin
    wrap_o = step_i && (cnt_q == last_i);
    cnt_d  = cnt_q;
    if (step_i) begin
      if (cnt_q == last_i) cnt_d = '0;
      else                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: line holds between column wraps
  assert_vcnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
  // R2: line steps by one at a column wrap that is not the frame end
  assert_vcnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q != last_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R2: line returns to zero after the last line
  assert_vcnt_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q == last_i) |=> (cnt_q == '0));
endmodule

// File: rtl/csg_decode.sv
module csg_decode
  import csg_pkg::*;
#(
  parameter int HW          = 11,
  parameter int VW          = 9,
  parameter int HSYNC_CLKS  = 113,
  parameter int EQ_CLKS     = 56,
  parameter int EQ_LINES    = 3,
  parameter int VS_LINES    = 3,
  parameter int H_ACT_START = 260,
  parameter int H_ACT_CLKS  = 1248,
  parameter int V_ACT_START = 24,
  parameter int V_ACT_LINES = 230
) (
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic [HW-1:0] hlast_i,
  input  logic [1:0]    mode_i,
  output logic          hs_no,
  output logic          vs_no,
  output logic          cs_no,
  output logic          act_o
);
  localparam int XW = HW + 1;
  localparam logic [XW-1:0] HSW  = XW'(HSYNC_CLKS);
  localparam logic [XW-1:0] EQW  = XW'(EQ_CLKS);
  localparam logic [XW-1:0] HA0  = XW'(H_ACT_START);
  localparam logic [XW-1:0] HA1  = XW'(H_ACT_START + H_ACT_CLKS);
  localparam logic [VW-1:0] VS0  = VW'(EQ_LINES);
  localparam logic [VW-1:0] VS1  = VW'(EQ_LINES + VS_LINES);
  localparam logic [VW-1:0] EQ1  = VW'(2 * EQ_LINES + VS_LINES);
  localparam logic [VW-1:0] VA0  = VW'(V_ACT_START);
  localparam logic [VW-1:0] VA1  = VW'(V_ACT_START + V_ACT_LINES);

  logic [XW-1:0] hx;
  logic [XW-1:0] htot;
  logic [XW-1:0] half;
  logic          in_hs;
  logic          broad_line;
  logic          eq_line;
  logic          eq_low;
  logic          broad_low;
  cs_mode_e      mode;

  always_comb begin
    hx         = {1'b0, hcnt_i};
    htot       = {1'b0, hlast_i} + 1'b1;
    half       = htot >> 1;
    mode       = cs_mode_e'(mode_i);
    in_hs      = hx < HSW;
    broad_line = (vcnt_i >= VS0) && (vcnt_i < VS1);
    eq_line    = (vcnt_i < VS0) || ((vcnt_i >= VS1) && (vcnt_i < EQ1));
    eq_low     = (hx < EQW) || ((hx >= half) && (hx < half + EQW));
    broad_low  = (hx < half - HSW) || ((hx >= half) && (hx < htot - HSW));

    hs_no = !in_hs;
    vs_no = !broad_line;
    act_o = (hx >= HA0) && (hx < HA1) && (vcnt_i >= VA0) && (vcnt_i < VA1);

    unique case (mode)
      CS_XNOR: cs_no = !(hs_no ^ vs_no);
      CS_SERR: begin
        if (broad_line)   cs_no = !broad_low;
        else if (eq_line) cs_no = !eq_low;
        else              cs_no = hs_no;
      end
      default: cs_no = hs_no & vs_no;
    endcase
  end
endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csg_pkg::*;
#(
  parameter int H_PAL_CLKS   = 1536,
  parameter int H_NTSC_CLKS  = 1524,
  parameter int V_PAL_LINES  = 312,
  parameter int V_NTSC_LINES = 262,
  parameter int HSYNC_CLKS   = 113,
  parameter int EQ_CLKS      = 56,
  parameter int EQ_LINES     = 3,
  parameter int VS_LINES     = 3,
  parameter int H_ACT_START  = 260,
  parameter int H_ACT_CLKS   = 1248,
  parameter int V_ACT_START  = 24,
  parameter int V_ACT_LINES  = 230,
  localparam int HW = $clog2((H_PAL_CLKS > H_NTSC_CLKS) ? H_PAL_CLKS : H_NTSC_CLKS),
  localparam int VW = $clog2((V_PAL_LINES > V_NTSC_LINES) ? V_PAL_LINES : V_NTSC_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          std_sel_i,
  input  logic [1:0]    cs_mode_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          csync_no,
  output logic          active_o,
  output logic [HW-1:0] x_o,
  output logic [VW-1:0] y_o
);
  localparam logic [HW-1:0] HLAST_PAL  = HW'(H_PAL_CLKS - 1);
  localparam logic [HW-1:0] HLAST_NTSC = HW'(H_NTSC_CLKS - 1);
  localparam logic [VW-1:0] VLAST_PAL  = VW'(V_PAL_LINES - 1);
  localparam logic [VW-1:0] VLAST_NTSC = VW'(V_NTSC_LINES - 1);

  logic          rst_sync_n;
  logic          run;
  vid_std_e      std_q, std_d;
  logic [HW-1:0] hlast;
  logic [VW-1:0] vlast;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          hwrap;
  logic          fwrap;
  logic          hs_n, vs_n, cs_n, act;

  csg_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign run   = 1'b1;
  assign hlast = (std_q == STD_NTSC) ? HLAST_NTSC : HLAST_PAL;
  assign vlast = (std_q == STD_NTSC) ? VLAST_NTSC : VLAST_PAL;

  csg_hcount #(.HW(HW)) u_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (run),
    .last_i (hlast),
    .cnt_o  (hcnt),
    .wrap_o (hwrap)
  );

  csg_vcount #(.VW(VW)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .step_i (hwrap),
    .last_i (vlast),
    .cnt_o  (vcnt),
    .wrap_o (fwrap)
  );

  // standard latch: loads only on the final clock of a frame
  always_comb begin
    std_d = std_q;
    if (fwrap) std_d = vid_std_e'(std_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) std_q <= STD_PAL;
    else             std_q <= std_d;
  end

  csg_decode #(
    .HW(HW), .VW(VW), .HSYNC_CLKS(HSYNC_CLKS), .EQ_CLKS(EQ_CLKS),
    .EQ_LINES(EQ_LINES), .VS_LINES(VS_LINES),
    .H_ACT_START(H_ACT_START), .H_ACT_CLKS(H_ACT_CLKS),
    .V_ACT_START(V_ACT_START), .V_ACT_LINES(V_ACT_LINES)
  ) u_dec (
    .hcnt_i  (hcnt),
    .vcnt_i  (vcnt),
    .hlast_i (hlast),
    .mode_i  (cs_mode_i),
    .hs_no   (hs_n),
    .vs_no   (vs_n),
    .cs_no   (cs_n),
    .act_o   (act)
  );

  // aligned output stage
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
      csync_no <= 1'b1;
      active_o <= 1'b0;
      x_o      <= '0;
      y_o      <= '0;
    end else begin
      hsync_no <= hs_n;
      vsync_no <= vs_n;
      csync_no <= cs_n;
      active_o <= act;
      x_o      <= hcnt;
      y_o      <= vcnt;
    end
  end

  // R10: the standard latch moves only at a frame boundary
  assert_std_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !$stable(std_q) |-> $past(fwrap));
  // R5: in AND mode a low frame sync forces composite sync low
  assert_and_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((($past(cs_mode_i) == 2'd0) || ($past(cs_mode_i) == 2'd3)) && !vsync_no) |-> !csync_no);
  // R4: frame sync only inside its line window
  assert_vsync_window_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !vsync_no |-> ((y_o >= VW'(EQ_LINES)) && (y_o < VW'(EQ_LINES + VS_LINES))));
  // R3: line sync is low at column zero
  assert_hsync_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((x_o == '0) && $past(rst_sync_n)) |-> !hsync_no);
endmodule

// File: tb/csync_gen_bench.sv
module csync_gen_bench;
  localparam int HP = 64, HN = 60, VP = 24, VN = 20;
  localparam int HSW = 5, EQW = 2, EQL = 3, VSL = 3;
  localparam int HA0 = 10, HAW = 40, VA0 = 10, VAL = 8;
  localparam int HW = $clog2(HP);
  localparam int VW = $clog2(VP);

  logic clk = 1'b0;
  logic rst_n;
  logic std_sel;
  logic [1:0] mode;
  logic hs_n, vs_n, cs_n, act;
  logic [HW-1:0] x;
  logic [VW-1:0] y;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csync_gen #(
    .H_PAL_CLKS(HP), .H_NTSC_CLKS(HN), .V_PAL_LINES(VP), .V_NTSC_LINES(VN),
    .HSYNC_CLKS(HSW), .EQ_CLKS(EQW), .EQ_LINES(EQL), .VS_LINES(VSL),
    .H_ACT_START(HA0), .H_ACT_CLKS(HAW), .V_ACT_START(VA0), .V_ACT_LINES(VAL)
  ) u_csync_gen (
    .clk_i(clk), .rst_ni(rst_n), .std_sel_i(std_sel), .cs_mode_i(mode),
    .hsync_no(hs_n), .vsync_no(vs_n), .csync_no(cs_n), .active_o(act),
    .x_o(x), .y_o(y)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  function automatic int htot(input bit s); return s ? HN : HP; endfunction
  function automatic int vtot(input bit s); return s ? VN : VP; endfunction
  function automatic bit f_hs(input int cx); return !(cx < HSW); endfunction
  function automatic bit f_vs(input int cy); return !(cy >= EQL && cy < EQL + VSL); endfunction
  function automatic bit f_act(input int cx, input int cy);
    return cx >= HA0 && cx < HA0 + HAW && cy >= VA0 && cy < VA0 + VAL;
  endfunction
  function automatic bit f_cs(input int cx, input int cy, input bit s, input int m);
    int h, hf;
    bit hs, vs;
    h = htot(s); hf = h / 2;
    hs = f_hs(cx); vs = f_vs(cy);
    if (m == 1) return !(hs ^ vs);
    if (m == 2) begin
      if (cy >= EQL && cy < EQL + VSL)
        return !((cx < hf - HSW) || (cx >= hf && cx < h - HSW));
      if (cy < EQL || (cy >= EQL + VSL && cy < 2 * EQL + VSL))
        return !((cx < EQW) || (cx >= hf && cx < hf + EQW));
      return hs;
    end
    return hs & vs;
  endfunction

  task automatic check_reset();
    check(x == 0 && y == 0, "R11", "position in reset", int'(x) + int'(y), 0);
    check(hs_n && vs_n && cs_n, "R11", "syncs in reset", {hs_n, vs_n, cs_n}, 7);
    check(!act, "R11", "active in reset", act, 0);
  endtask

  int px, py, skip, frames;
  bit have_prev, std_cur;

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (skip > 0) begin
        skip--;
      end else begin
        int ex, ey;
        if (have_prev) begin
          if (px == htot(std_cur) - 1) begin
            ex = 0;
            if (py == vtot(std_cur) - 1) begin
              ey = 0;
              std_cur = std_sel; // R10: standard taken at frame end
              frames++;
            end else ey = py + 1;
          end else begin
            ex = px + 1; ey = py;
          end
          check(int'(x) == ex, "R1", "column", x, ex);
          check(int'(y) == ey, (ex == 0) ? "R2" : "R10", "line", y, ey);
        end
        check(hs_n == f_hs(x), "R3", "hsync", hs_n, f_hs(x));
        check(vs_n == f_vs(y), "R4", "vsync", vs_n, f_vs(y));
        check(cs_n == f_cs(x, y, std_cur, mode),
              (mode == 1) ? "R6" : (mode == 2) ? ((y < 9) ? "R7_R8" : "R8") : "R5",
              "csync", cs_n, f_cs(x, y, std_cur, mode));
        check(act == f_act(x, y), "R9", "active", act, f_act(x, y));
        px = x; py = y; have_prev = 1'b1;
      end
      // stimulus after sampling
      if (frames < 8) begin
        if (x == 0 && y == 0) mode = 2'(frames % 4);
      end else if ($urandom_range(0, 299) == 0) begin
        mode = 2'($urandom_range(0, 3));
      end
      if (x == 0 && y == 12 && $urandom_range(0, 1) == 1) std_sel = !std_sel;
    end
  endtask

  task automatic do_reset(input bit sel);
    rst_n = 1'b0;
    std_sel = sel;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_reset();
    end
    rst_n = 1'b1;
    have_prev = 1'b0; std_cur = 1'b0; skip = 3; frames = 0;
  endtask

  initial begin
    void'($urandom(32'd20231));
    mode = 2'd0;
    rst_n = 1'b0;
    std_sel = 1'b1;
    // R10: NTSC requested through reset, first frame must still be PAL
    do_reset(1'b1);
    run_cycles(40000);
    // R11: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset();
    do_reset(1'b1);
    run_cycles(40000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule